// File: doc/BRIEF.md
# Instruction Emulation Handshake Controller

This block sits between a functional pipeline and a host-side software emulator. When the pipeline reaches an instruction it cannot execute, it offers the instruction word and its PC to the block. The block then runs a fixed sequence. First, and only if flush mode is selected, it asks the functional cache to write back its lines. Next it streams every architectural register to the host as a register-sync message. Then it sends one emulate request. It waits for the host's reply. While waiting, it applies any register updates the host sends back. The host ends the exchange with a new-PC message, and the block returns that PC to the pipeline with a one-cycle completion pulse.

The block holds the architectural register file itself. The pipeline reaches it through a write port and a read port that work while the block is idle. The controller takes over the single read port while it streams registers out. It takes over the single write port while it applies host updates. Register 31 is a constant zero: it is never stored, never sent and never written. Both host channels use valid/ready handshakes. Only one emulation can be in flight at a time.

Top module: `emu_handoff_ctrl`

## Requirements
- R1: After reset, trap_ready is 1 and out_valid, in_ready, flush_req and done_pulse are all 0.
- R2: A trap is taken only while trap_ready is 1. trap_ready stays 0 from the cycle after it is taken until the cycle after done_pulse, so only one emulation is outstanding.
- R3: With flush_mode=1 at trap time, flush_req rises in the next cycle. No outbound message is sent until flush_done is seen, and flush_req then falls. flush_done has no effect while no flush is pending.
- R4: With flush_mode=0 at trap time, flush_req stays 0 and register streaming starts at once.
- R5: Registers 0 to 30 are sent in ascending order. Each is one message with out_kind=0, out_name set to the register number and out_data set to its value. Register 31 is never sent. While out_valid=1 and out_ready=0, every outbound field holds its value.
- R6: After register 30 is accepted, one emulate message follows with out_kind=1. It carries out_inst set to the trapped instruction word and out_data set to the trapped PC.
- R7: in_ready is 1 only while the reply is awaited. Each accepted inbound message with in_kind=0 writes in_data into register in_name, in arrival order, so a later write to the same register wins.
- R8: An inbound write to register 31 is dropped, and a read of register 31 returns 0.
- R9: An accepted inbound message with in_kind=1 ends the wait. In the next cycle done_pulse is 1 for exactly one cycle, and done_pc holds that message's in_data.
- R10: A pipeline write through the pl_wr port takes effect only while trap_ready is 1, and is ignored otherwise. pl_rd_data shows the register named by pl_rd_name one cycle later, while idle.
- R11: An inbound message with in_kind 2 or 3 is accepted but changes neither a register nor the completion state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | Pipeline offers an instruction to emulate |
| trap_ready | output | 1 | Block is idle and takes the offer |
| trap_inst | input | 32 | Instruction word |
| trap_pc | input | 64 | Virtual PC of the instruction |
| flush_mode | input | 1 | 1: flush the cache before streaming, 0: go straight to streaming |
| flush_req | output | 1 | Request to the functional cache to write back its lines |
| flush_done | input | 1 | Cache reports the flush finished |
| pl_wr_en | input | 1 | Pipeline register write enable |
| pl_wr_name | input | 5 | Pipeline write register number |
| pl_wr_data | input | 64 | Pipeline write value |
| pl_rd_name | input | 5 | Pipeline read register number |
| pl_rd_data | output | 64 | Pipeline read value, one cycle later |
| out_valid | output | 1 | Outbound message valid |
| out_ready | input | 1 | Host accepts the outbound message |
| out_kind | output | 2 | 0 register sync, 1 emulate request |
| out_name | output | 5 | Register number of a sync message |
| out_data | output | 64 | Register value, or PC for an emulate request |
| out_inst | output | 32 | Instruction word of an emulate request |
| in_valid | input | 1 | Inbound message valid |
| in_ready | output | 1 | Block accepts the inbound message |
| in_kind | input | 2 | 0 register sync, 1 new PC, 2 and 3 ignored |
| in_name | input | 5 | Register number of a sync message |
| in_data | input | 64 | Register value or new PC |
| done_pulse | output | 1 | One-cycle completion pulse |
| done_pc | output | 64 | New fetch address, valid with done_pulse |

## Verification
The properties assume reset is held high before the first trap. They also assume that the host and the pipeline count a transfer only on a cycle when valid and ready are both high. None of them assumes that the host keeps out_ready high, or that it holds in_valid up, on any particular cycle. The stimulus changes inputs only on falling clock edges and holds each inbound message until ready has been seen high. It deliberately withholds out_ready for several cycles, pulses flush_done while idle, and attempts pipeline writes while busy. All of these stay within what the properties assume.

// File: rtl/emu_handoff_pkg.sv
package emu_handoff_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_SYNC_OUT,
    ST_EMULATE,
    ST_WAIT_RESP,
    ST_DONE
  } emu_state_t;

  localparam int KIND_W = 2;

  // outbound message kinds
  localparam logic [KIND_W-1:0] OUT_REG_SYNC = 2'd0;
  localparam logic [KIND_W-1:0] OUT_EMULATE  = 2'd1;

  // inbound message kinds
  localparam logic [KIND_W-1:0] IN_REG_SYNC  = 2'd0;
  localparam logic [KIND_W-1:0] IN_NEW_PC    = 2'd1;

endpackage

// File: rtl/emu_regfile.sv
module emu_regfile #(
  parameter int NREG   = 32,
  parameter int DATA_W = 64,
  parameter int NAME_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [NAME_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NAME_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [NAME_W-1:0] ZERO_REG = NAME_W'(NREG - 1);

  // plain one-write one-read array with a registered read, block RAM friendly
  logic [DATA_W-1:0] mem [NREG];
  logic [DATA_W-1:0] rd_q;
  logic              zero_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q   <= mem[raddr];
    zero_q <= (raddr == ZERO_REG);
  end

  // the constant-zero register is masked on the way out instead of stored
  assign rdata = zero_q ? '0 : rd_q;

  // R8: callers never route a write to the constant-zero register
  assert_no_zero_write_R8: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr != ZERO_REG))
    else $error("write reached the zero register");

endmodule

// File: rtl/emu_inbound.sv
module emu_inbound
  import emu_handoff_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int DATA_W = 64,
  parameter int PC_W   = 64,
  parameter int NAME_W = $clog2(NREG)
) (
  input  logic              in_valid,
  input  logic              in_ready,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [NAME_W-1:0] in_name,
  input  logic [DATA_W-1:0] in_data,
  output logic              host_we,
  output logic [NAME_W-1:0] host_waddr,
  output logic [DATA_W-1:0] host_wdata,
  output logic              resp_take,
  output logic [PC_W-1:0]   resp_pc
);

  localparam logic [NAME_W-1:0] ZERO_REG = NAME_W'(NREG - 1);

  logic taken;

  always_comb begin
    taken      = in_valid && in_ready;
    host_we    = taken && (in_kind == IN_REG_SYNC) && (in_name != ZERO_REG);
    host_waddr = in_name;
    host_wdata = in_data;
    resp_take  = taken && (in_kind == IN_NEW_PC);
    resp_pc    = PC_W'(in_data);
  end

endmodule

// File: rtl/emu_seq.sv
module emu_seq
  import emu_handoff_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int DATA_W = 64,
  parameter int PC_W   = 64,
  parameter int INST_W = 32,
  parameter int NAME_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_valid,
  output logic              trap_ready,
  input  logic [INST_W-1:0] trap_inst,
  input  logic [PC_W-1:0]   trap_pc,
  input  logic              flush_mode,
  output logic              flush_req,
  input  logic              flush_done,
  output logic              rf_sel_sync,
  output logic [NAME_W-1:0] rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [KIND_W-1:0] out_kind,
  output logic [NAME_W-1:0] out_name,
  output logic [DATA_W-1:0] out_data,
  output logic [INST_W-1:0] out_inst,
  output logic              in_ready,
  input  logic              resp_take,
  input  logic [PC_W-1:0]   resp_pc,
  output logic              done_pulse,
  output logic [PC_W-1:0]   done_pc
);

  localparam logic [NAME_W-1:0] ZERO_REG  = NAME_W'(NREG - 1);
  localparam logic [NAME_W-1:0] LAST_SYNC = NAME_W'(NREG - 2);

  emu_state_t        state_q;
  logic [NAME_W-1:0] idx_q;
  logic              rd_wait_q;
  logic [INST_W-1:0] inst_q;
  logic [PC_W-1:0]   pc_q;

  assign trap_ready  = (state_q == ST_IDLE);
  assign in_ready    = (state_q == ST_WAIT_RESP);
  assign busy        = (state_q != ST_IDLE);
  assign rf_sel_sync = (state_q == ST_SYNC_OUT);
  assign rf_raddr    = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      rd_wait_q  <= 1'b0;
      inst_q     <= '0;
      pc_q       <= '0;
      flush_req  <= 1'b0;
      out_valid  <= 1'b0;
      out_kind   <= OUT_REG_SYNC;
      out_name   <= '0;
      out_data   <= '0;
      out_inst   <= '0;
      done_pulse <= 1'b0;
      done_pc    <= '0;
    end else begin
      done_pulse <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (trap_valid) begin
            inst_q    <= trap_inst;
            pc_q      <= trap_pc;
            idx_q     <= '0;
            rd_wait_q <= 1'b0;
            if (flush_mode) begin
              flush_req <= 1'b1;
              state_q   <= ST_FLUSH;
            end else begin
              state_q   <= ST_SYNC_OUT;
            end
          end
        end
        ST_FLUSH: begin
          if (flush_done) begin
            flush_req <= 1'b0;
            state_q   <= ST_SYNC_OUT;
          end
        end
        ST_SYNC_OUT: begin
          if (out_valid) begin
            if (out_ready) begin
              if (idx_q == LAST_SYNC) begin
                // emulate request replaces the last sync without a gap
                out_kind <= OUT_EMULATE;
                out_name <= '0;
                out_data <= DATA_W'(pc_q);
                out_inst <= inst_q;
                state_q  <= ST_EMULATE;
              end else begin
                out_valid <= 1'b0;
                idx_q     <= idx_q + NAME_W'(1);
              end
            end
          end else if (rd_wait_q) begin
            out_valid <= 1'b1;
            out_kind  <= OUT_REG_SYNC;
            out_name  <= idx_q;
            out_data  <= rf_rdata;
            rd_wait_q <= 1'b0;
          end else begin
            rd_wait_q <= 1'b1;
          end
        end
        ST_EMULATE: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            state_q   <= ST_WAIT_RESP;
          end
        end
        ST_WAIT_RESP: begin
          if (resp_take) begin
            done_pulse <= 1'b1;
            done_pc    <= resp_pc;
            state_q    <= ST_DONE;
          end
        end
        ST_DONE: begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5: a stalled outbound message keeps every field
  assert_payload_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_name)
                                   && $stable(out_data) && $stable(out_inst)))
    else $error("outbound payload changed while stalled");

  // R5: the zero register is never streamed
  assert_no_zero_sync_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == OUT_REG_SYNC) |-> (out_name != ZERO_REG))
    else $error("zero register sent");

  // R3: nothing moves on either channel while the flush is pending
  assert_flush_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> (!out_valid && !in_ready))
    else $error("message traffic during flush");

  // R2: an idle block has nothing outstanding
  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (rst)
    trap_ready |-> (!out_valid && !flush_req))
    else $error("idle with work outstanding");

  // R9: completion is a single-cycle pulse caused by a new-PC reply
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse)
    else $error("done pulse longer than one cycle");

  assert_done_after_resp_R9: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> $past(resp_take))
    else $error("done without a new-PC reply");

endmodule

// File: rtl/emu_handoff_ctrl.sv
module emu_handoff_ctrl
  import emu_handoff_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int DATA_W = 64,
  parameter int PC_W   = 64,
  parameter int INST_W = 32,
  parameter int NAME_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_valid,
  output logic              trap_ready,
  input  logic [INST_W-1:0] trap_inst,
  input  logic [PC_W-1:0]   trap_pc,
  input  logic              flush_mode,
  output logic              flush_req,
  input  logic              flush_done,
  input  logic              pl_wr_en,
  input  logic [NAME_W-1:0] pl_wr_name,
  input  logic [DATA_W-1:0] pl_wr_data,
  input  logic [NAME_W-1:0] pl_rd_name,
  output logic [DATA_W-1:0] pl_rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [KIND_W-1:0] out_kind,
  output logic [NAME_W-1:0] out_name,
  output logic [DATA_W-1:0] out_data,
  output logic [INST_W-1:0] out_inst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [NAME_W-1:0] in_name,
  input  logic [DATA_W-1:0] in_data,
  output logic              done_pulse,
  output logic [PC_W-1:0]   done_pc
);

  localparam logic [NAME_W-1:0] ZERO_REG = NAME_W'(NREG - 1);

  logic              busy;
  logic              seq_sel_sync;
  logic [NAME_W-1:0] seq_raddr;
  logic              host_we;
  logic [NAME_W-1:0] host_waddr;
  logic [DATA_W-1:0] host_wdata;
  logic              resp_take;
  logic [PC_W-1:0]   resp_pc;
  logic              rf_we;
  logic [NAME_W-1:0] rf_waddr;
  logic [DATA_W-1:0] rf_wdata;
  logic [NAME_W-1:0] rf_raddr;
  logic [DATA_W-1:0] rf_rdata;

  // single write port: the host owns it while busy, the pipeline while idle
  always_comb begin
    if (busy) begin
      rf_we    = host_we;
      rf_waddr = host_waddr;
      rf_wdata = host_wdata;
    end else begin
      rf_we    = pl_wr_en && (pl_wr_name != ZERO_REG);
      rf_waddr = pl_wr_name;
      rf_wdata = pl_wr_data;
    end
    rf_raddr = seq_sel_sync ? seq_raddr : pl_rd_name;
  end

  assign pl_rd_data = rf_rdata;

  emu_regfile #(
    .NREG(NREG), .DATA_W(DATA_W), .NAME_W(NAME_W)
  ) u_rf (
    .clk(clk), .rst(rst),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(rf_raddr), .rdata(rf_rdata)
  );

  emu_inbound #(
    .NREG(NREG), .DATA_W(DATA_W), .PC_W(PC_W), .NAME_W(NAME_W)
  ) u_in (
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_name(in_name), .in_data(in_data),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .resp_take(resp_take), .resp_pc(resp_pc)
  );

  emu_seq #(
    .NREG(NREG), .DATA_W(DATA_W), .PC_W(PC_W), .INST_W(INST_W), .NAME_W(NAME_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .trap_valid(trap_valid), .trap_ready(trap_ready),
    .trap_inst(trap_inst), .trap_pc(trap_pc),
    .flush_mode(flush_mode), .flush_req(flush_req), .flush_done(flush_done),
    .rf_sel_sync(seq_sel_sync), .rf_raddr(seq_raddr), .rf_rdata(rf_rdata),
    .busy(busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_name(out_name), .out_data(out_data), .out_inst(out_inst),
    .in_ready(in_ready), .resp_take(resp_take), .resp_pc(resp_pc),
    .done_pulse(done_pulse), .done_pc(done_pc)
  );

endmodule

// File: tb/sim_emu_handoff_ctrl.sv
module sim_emu_handoff_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trap_valid = 1'b0;
  logic        trap_ready;
  logic [31:0] trap_inst = '0;
  logic [63:0] trap_pc = '0;
  logic        flush_mode = 1'b0;
  logic        flush_req;
  logic        flush_done = 1'b0;
  logic        pl_wr_en = 1'b0;
  logic [4:0]  pl_wr_name = '0;
  logic [63:0] pl_wr_data = '0;
  logic [4:0]  pl_rd_name = '0;
  logic [63:0] pl_rd_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_kind;
  logic [4:0]  out_name;
  logic [63:0] out_data;
  logic [31:0] out_inst;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_kind = '0;
  logic [4:0]  in_name = '0;
  logic [63:0] in_data = '0;
  logic        done_pulse;
  logic [63:0] done_pc;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_rf [32];

  always #5 clk = ~clk;

  emu_handoff_ctrl u0 (
    .clk(clk), .rst(rst),
    .trap_valid(trap_valid), .trap_ready(trap_ready), .trap_inst(trap_inst), .trap_pc(trap_pc),
    .flush_mode(flush_mode), .flush_req(flush_req), .flush_done(flush_done),
    .pl_wr_en(pl_wr_en), .pl_wr_name(pl_wr_name), .pl_wr_data(pl_wr_data),
    .pl_rd_name(pl_rd_name), .pl_rd_data(pl_rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_name(out_name), .out_data(out_data), .out_inst(out_inst),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_name(in_name), .in_data(in_data),
    .done_pulse(done_pulse), .done_pc(done_pc)
  );

  typedef struct packed {
    logic        fm;
    logic [31:0] inst;
    logic [63:0] pc;
    logic [63:0] npc;
    logic [4:0]  wa;
    logic [4:0]  wb;
  } vec_t;

  // stimulus and expected completion PC per row
  localparam vec_t VECS [4] = '{
    '{1'b0, 32'h0400_0013, 64'h0000_0000_0001_0000, 64'h0000_0000_0001_0004, 5'd1,  5'd2},
    '{1'b1, 32'hDEAD_BEEF, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0000_0000_0000_0000, 5'd30, 5'd0},
    '{1'b0, 32'h0000_0000, 64'h8000_0000_0000_0000, 64'h1234_5678_9ABC_DEF0, 5'd0,  5'd30},
    '{1'b1, 32'hFFFF_FFFF, 64'h0000_1000_2000_3000, 64'hFFFF_FFFF_FFFF_FFFF, 5'd17, 5'd17}
  };

  function automatic logic [63:0] pat(input int r, input int i, input int salt);
    logic [31:0] lo;
    lo = (32'(i) * 32'h0100_0193) + 32'(r);
    return {8'(r), 8'(salt), 16'hBEEF ^ 16'(i), lo};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pl_write(input int name, input logic [63:0] val);
    pl_wr_en = 1'b1; pl_wr_name = 5'(name); pl_wr_data = val;
    @(negedge clk);
    pl_wr_en = 1'b0;
  endtask

  task automatic read_check(input int name, input string req);
    pl_rd_name = 5'(name);
    @(negedge clk);
    check($sformatf("%s readback reg %0d", req, name), pl_rd_data, exp_rf[name]);
  endtask

  task automatic send_in(input logic [1:0] kind, input int name, input logic [63:0] val);
    in_valid = 1'b1; in_kind = kind; in_name = 5'(name); in_data = val;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_emulation(input vec_t v, input int row, input bit stress);
    for (int i = 0; i < 31; i++) begin
      exp_rf[i] = pat(row, i, 1);
      pl_write(i, exp_rf[i]);
    end
    if (stress) out_ready = 1'b0;
    trap_valid = 1'b1; trap_inst = v.inst; trap_pc = v.pc; flush_mode = v.fm;
    @(negedge clk);
    trap_valid = 1'b0;
    check("R2 trap_ready low once taken", 64'(trap_ready), 64'd0);
    if (v.fm) begin
      check("R3 flush_req raised", 64'(flush_req), 64'd1);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check("R3 no message before flush_done", 64'(out_valid), 64'd0);
      end
      flush_done = 1'b1;
      @(negedge clk);
      flush_done = 1'b0;
      check("R3 flush_req dropped", 64'(flush_req), 64'd0);
    end else begin
      check("R4 no flush in hybrid mode", 64'(flush_req), 64'd0);
    end
    for (int n = 0; n < 31; n++) begin
      while (!out_valid) @(negedge clk);
      check("R5 sync kind", 64'(out_kind), 64'd0);
      check("R5 sync name order", 64'(out_name), 64'(n));
      check($sformatf("R5 sync value reg %0d", n), out_data, exp_rf[n]);
      if (n == 3) begin
        check("R7 in_ready low while streaming", 64'(in_ready), 64'd0);
        check("R2 no second trap while busy", 64'(trap_ready), 64'd0);
      end
      if (stress && n == 0) begin
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          check("R5 stalled valid held", 64'(out_valid), 64'd1);
          check("R5 stalled name held", 64'(out_name), 64'd0);
          check("R5 stalled data held", out_data, exp_rf[0]);
        end
        out_ready = 1'b1;
      end
      @(negedge clk);
    end
    while (!out_valid) @(negedge clk);
    check("R6 emulate kind (R5 reg 31 skipped)", 64'(out_kind), 64'd1);
    check("R6 emulate inst", 64'(out_inst), 64'(v.inst));
    check("R6 emulate pc", out_data, v.pc);
    @(negedge clk);
    check("R7 in_ready while waiting", 64'(in_ready), 64'd1);
    send_in(2'd0, v.wa, pat(row, 100, 2)); exp_rf[v.wa] = pat(row, 100, 2);
    send_in(2'd0, v.wb, pat(row, 101, 3)); exp_rf[v.wb] = pat(row, 101, 3);
    send_in(2'd0, v.wa, pat(row, 102, 4)); exp_rf[v.wa] = pat(row, 102, 4);
    send_in(2'd0, 31, 64'hFFFF_0000_FFFF_0000);  // R8 dropped
    if (stress) begin
      pl_write(3, 64'h0BAD_0BAD_0BAD_0BAD);  // R10 ignored while busy
      send_in(2'd2, 4, 64'h0666_0666_0666_0666);  // R11 ignored kind
      check("R11 ignored kind gives no done", 64'(done_pulse), 64'd0);
      check("R11 still waiting", 64'(in_ready), 64'd1);
    end
    send_in(2'd1, 0, v.npc);
    check("R9 done pulse", 64'(done_pulse), 64'd1);
    check("R9 done pc", done_pc, v.npc);
    @(negedge clk);
    check("R9 pulse lasts one cycle", 64'(done_pulse), 64'd0);
    check("R2 trap_ready back after done", 64'(trap_ready), 64'd1);
    check("R7 in_ready low after done", 64'(in_ready), 64'd0);
    for (int i = 0; i < 32; i++) read_check(i, "R7 R8 R10 R11");
  endtask

  initial begin
    exp_rf[31] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 trap_ready after reset", 64'(trap_ready), 64'd1);
    check("R1 out_valid after reset", 64'(out_valid), 64'd0);
    check("R1 in_ready after reset", 64'(in_ready), 64'd0);
    check("R1 flush_req after reset", 64'(flush_req), 64'd0);
    check("R1 done_pulse after reset", 64'(done_pulse), 64'd0);

    // R3: flush_done while idle is ignored
    flush_done = 1'b1;
    @(negedge clk);
    flush_done = 1'b0;
    @(negedge clk);
    check("R3 stray flush_done ignored", 64'(flush_req), 64'd0);
    check("R3 stray flush_done keeps idle", 64'(trap_ready), 64'd1);
    check("R3 stray flush_done sends nothing", 64'(out_valid), 64'd0);

    // R8 and R10: pipeline write to reg 31 dropped, ordinary write visible next cycle
    pl_write(31, 64'h1111_2222_3333_4444);
    read_check(31, "R8");
    exp_rf[9] = 64'h0123_4567_89AB_CDEF;
    pl_write(9, exp_rf[9]);
    read_check(9, "R10");

    for (int r = 0; r < 4; r++) run_emulation(VECS[r], r, 1'b0);

    // corner run: stalled outbound, busy pipeline write, ignored inbound kind
    run_emulation('{1'b0, 32'h1357_9BDF, 64'h0000_0000_0040_0000, 64'h0000_0000_0040_0010,
                    5'd5, 5'd6}, 7, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule